// File: doc/BRIEF.md
# Multi-Requester Prefix-Sum Unit

This block keeps a small bank of shared counters, called bases, that many thread cores can bump at the same moment. Each requester names a base and offers an increment of 0 or 1. In return it gets the value the base held before its own share was added. Requests that hit the same base in the same cycle are not queued. They are merged into one prefix over their one-bit increments, ordered by requester index. Each requester therefore sees a different old value, and the base moves once by the sum of the increments.

A separate load port sets a base to any value, for example before a parallel section hands out work. When a load and requests target the same base in one cycle, the load is applied first and the requests build on the loaded value. Results come back exactly one cycle after the request, flagged by a per-requester response valid. The request port never stalls outside reset, so the cost of coordinating does not grow with the number of requesters.

Top module: `prefix_sum_unit`

## Requirements
- R1: While reset is asserted, every `rsp_valid` bit and every `req_ready` bit is 0, and all bases hold 0 once reset is released.
- R2: Outside reset, every `req_ready` bit is 1, so every valid request is accepted in the cycle it is presented.
- R3: `rsp_valid[k]` is 1 in the cycle after `req_valid[k]` was 1, and 0 in the cycle after it was 0.
- R4: A requester that is alone on its base receives that base's current value. The base index for requester k is `req_idx[k*2 +: 2]`.
- R5: Among same-cycle requests to one base, requester k receives the base plus the number of requesters with a lower index that target the same base with increment 1.
- R6: A base advances once per cycle by the number of accepted requests on it whose `req_inc` bit is 1.
- R7: Requests to different bases in the same cycle do not affect each other's results or bases.
- R8: A load writes `ld_data` into base `ld_idx`, and a request in a later cycle receives that value.
- R9: When a load and requests target the same base in one cycle, the requests see the loaded value, and the base ends at the loaded value plus their increment count.
- R10: Base arithmetic wraps modulo 2^32.
- R11: A request with increment 0 still receives the prefix value but leaves the base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Request valid, one bit per requester |
| req_inc | input | 8 | Increment (0 or 1), one bit per requester |
| req_idx | input | 16 | Base index, 2 bits per requester, requester k at bits k*2+1:k*2 |
| req_ready | output | 8 | Request accepted, one bit per requester |
| ld_valid | input | 1 | Load strobe |
| ld_idx | input | 2 | Base index to load |
| ld_data | input | 32 | Value to load |
| rsp_valid | output | 8 | Response valid, one cycle after the request |
| rsp_data | output | 256 | Old value per requester, 32 bits each, requester k at bits k*32+31:k*32 |

## Verification
The bench builds the unit with its defaults: 8 requesters, 4 bases and 32-bit values. With 8 requesters, a single cycle can carry a full eight-deep prefix on one base, mixed increment patterns and traffic split across all four bases at once. The 32-bit width lets a load near the top of the range drive a wrap within three requests. The bench's reference handles requests one at a time in index order, so the parallel prefix is checked against a different formulation of the same rule.

// File: rtl/psu_pkg.sv
package psu_pkg;
  // Population count over a vector of up to 64 request bits.
  function automatic int unsigned ones64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  // Mask of the bit positions strictly below position k.
  function automatic logic [63:0] below_mask(input int k);
    return (64'd1 << k) - 64'd1;
  endfunction
endpackage

// File: rtl/psu_match.sv
module psu_match #(
  parameter int N_REQ  = 8,
  parameter int N_BASE = 4,
  parameter int IW     = 2
) (
  input  logic [N_REQ-1:0]        grant,
  input  logic [N_REQ-1:0]        inc,
  input  logic [N_REQ*IW-1:0]     idx,
  output logic [N_BASE*N_REQ-1:0] hit_flat
);
  for (genvar b = 0; b < N_BASE; b++) begin : g_base
    for (genvar k = 0; k < N_REQ; k++) begin : g_req
      assign hit_flat[b*N_REQ+k] = grant[k] && inc[k] && (idx[k*IW +: IW] == IW'(b));
    end
  end
endmodule

// File: rtl/psu_bank.sv
module psu_bank
  import psu_pkg::*;
#(
  parameter int N_REQ  = 8,
  parameter int N_BASE = 4,
  parameter int W      = 32,
  parameter int IW     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  input  logic [IW-1:0]           ld_idx,
  input  logic [W-1:0]            ld_data,
  input  logic [N_BASE*N_REQ-1:0] hit_flat,
  output logic [N_BASE*W-1:0]     eff_flat,
  output logic [N_BASE*W-1:0]     base_flat
);
  for (genvar b = 0; b < N_BASE; b++) begin : g_base
    logic [W-1:0] base_q;
    logic         ld_here;
    logic [W-1:0] eff;
    assign ld_here = ld_valid && (ld_idx == IW'(b));
    assign eff     = ld_here ? ld_data : base_q;
    always_ff @(posedge clk) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= eff + W'(ones64(64'(hit_flat[b*N_REQ +: N_REQ])));
    end
    assign eff_flat[b*W +: W]  = eff;
    assign base_flat[b*W +: W] = base_q;
  end
endmodule

// File: rtl/psu_prefix.sv
module psu_prefix
  import psu_pkg::*;
#(
  parameter int N_REQ  = 8,
  parameter int N_BASE = 4,
  parameter int W      = 32,
  parameter int IW     = 2
) (
  input  logic [N_REQ*IW-1:0]     idx,
  input  logic [N_BASE*N_REQ-1:0] hit_flat,
  input  logic [N_BASE*W-1:0]     eff_flat,
  output logic [N_REQ*W-1:0]      res_flat
);
  for (genvar k = 0; k < N_REQ; k++) begin : g_req
    localparam logic [63:0] LOWER = below_mask(k);
    logic [IW-1:0]    my_idx;
    logic [N_REQ-1:0] row;
    logic [W-1:0]     base;
    assign my_idx = idx[k*IW +: IW];
    assign row    = hit_flat[int'(my_idx)*N_REQ +: N_REQ];
    assign base   = eff_flat[int'(my_idx)*W +: W];
    assign res_flat[k*W +: W] = base + W'(ones64(64'(row) & LOWER));
  end
endmodule

// File: rtl/prefix_sum_unit.sv
module prefix_sum_unit #(
  parameter int N_REQ  = 8,
  parameter int N_BASE = 4,
  parameter int W      = 32,
  localparam int IW    = $clog2(N_BASE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_REQ-1:0]     req_valid,
  input  logic [N_REQ-1:0]     req_inc,
  input  logic [N_REQ*IW-1:0]  req_idx,
  output logic [N_REQ-1:0]     req_ready,
  input  logic                 ld_valid,
  input  logic [IW-1:0]        ld_idx,
  input  logic [W-1:0]         ld_data,
  output logic [N_REQ-1:0]     rsp_valid,
  output logic [N_REQ*W-1:0]   rsp_data
);
  // Named internal events for the checker.
  logic [N_REQ-1:0]        grant;
  logic [N_BASE*N_REQ-1:0] hit_flat;
  logic [N_BASE*W-1:0]     eff_flat;
  logic [N_BASE*W-1:0]     base_flat;
  logic [N_REQ*W-1:0]      res_flat;

  assign req_ready = {N_REQ{rst_n}};
  assign grant     = req_valid & req_ready;

  psu_match #(.N_REQ(N_REQ), .N_BASE(N_BASE), .IW(IW)) u_match (
    .grant(grant), .inc(req_inc), .idx(req_idx), .hit_flat(hit_flat)
  );

  psu_bank #(.N_REQ(N_REQ), .N_BASE(N_BASE), .W(W), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
    .ld_data(ld_data), .hit_flat(hit_flat), .eff_flat(eff_flat),
    .base_flat(base_flat)
  );

  psu_prefix #(.N_REQ(N_REQ), .N_BASE(N_BASE), .W(W), .IW(IW)) u_prefix (
    .idx(req_idx), .hit_flat(hit_flat), .eff_flat(eff_flat), .res_flat(res_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= grant;
      rsp_data  <= res_flat;
    end
  end
endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int N_REQ  = 8,
  parameter int N_BASE = 4,
  parameter int W      = 32,
  parameter int IW     = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REQ-1:0]        req_valid,
  input logic [N_REQ-1:0]        req_ready,
  input logic [N_REQ*IW-1:0]     req_idx,
  input logic [N_REQ-1:0]        grant,
  input logic                    ld_valid,
  input logic [IW-1:0]           ld_idx,
  input logic [W-1:0]            ld_data,
  input logic [N_REQ-1:0]        rsp_valid,
  input logic [N_REQ*W-1:0]      rsp_data,
  input logic [N_BASE*N_REQ-1:0] hit_flat,
  input logic [N_BASE*W-1:0]     eff_flat,
  input logic [N_BASE*W-1:0]     base_flat
);
  // R2: never stalls outside reset
  a_r2_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (&req_ready));

  // R3: response one cycle after each accepted request
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(req_valid)));

  // R4: requester 0 always sees the effective base untouched
  a_r4_lowest_sees_base: assert property (@(posedge clk) disable iff (!rst_n)
    grant[0] |=> (rsp_data[W-1:0] == $past(eff_flat[int'(req_idx[IW-1:0])*W +: W])));

  for (genvar b = 0; b < N_BASE; b++) begin : g_base
    // R6: base steps by the count of incrementing hits
    a_r6_base_step: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_valid && ld_idx == IW'(b)) |=>
        (base_flat[b*W +: W] == $past(base_flat[b*W +: W])
                                + W'($past($countones(hit_flat[b*N_REQ +: N_REQ])))));

    // R8: a load with no increments lands exactly
    a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_idx == IW'(b) && hit_flat[b*N_REQ +: N_REQ] == '0) |=>
        (base_flat[b*W +: W] == $past(ld_data)));
  end
endmodule

bind prefix_sum_unit psu_checker #(
  .N_REQ(N_REQ), .N_BASE(N_BASE), .W(W), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_idx(req_idx), .grant(grant), .ld_valid(ld_valid), .ld_idx(ld_idx),
  .ld_data(ld_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .hit_flat(hit_flat), .eff_flat(eff_flat), .base_flat(base_flat)
);

// File: tb/prefix_sum_unit_test.sv
`timescale 1ns/1ps
module prefix_sum_unit_test;
  localparam int NR = 8;
  localparam int NB = 4;
  localparam int W  = 32;
  localparam int IW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NR-1:0]     req_valid = '0;
  logic [NR-1:0]     req_inc = '0;
  logic [NR*IW-1:0]  req_idx = '0;
  logic [NR-1:0]     req_ready;
  logic              ld_valid = 1'b0;
  logic [IW-1:0]     ld_idx = '0;
  logic [W-1:0]      ld_data = '0;
  logic [NR-1:0]     rsp_valid;
  logic [NR*W-1:0]   rsp_data;

  prefix_sum_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inc(req_inc),
    .req_idx(req_idx), .req_ready(req_ready), .ld_valid(ld_valid),
    .ld_idx(ld_idx), .ld_data(ld_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [W-1:0] mb [NB];

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Serial reference: load first, then requesters one by one in index order.
  task automatic apply(input logic [NR-1:0] v, input logic [NR-1:0] inc,
                       input logic [NR*IW-1:0] ix, input bit lv,
                       input logic [IW-1:0] li, input logic [W-1:0] ld, input string tag);
    logic [W-1:0] exp [NR];
    req_valid = v; req_inc = inc; req_idx = ix;
    ld_valid = lv; ld_idx = li; ld_data = ld;
    if (lv) mb[li] = ld;
    for (int k = 0; k < NR; k++) begin
      exp[k] = '0;
      if (v[k]) begin
        exp[k] = mb[ix[k*IW +: IW]];
        if (inc[k]) mb[ix[k*IW +: IW]] = mb[ix[k*IW +: IW]] + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == v, {tag, " R3 rsp_valid"}, W'(rsp_valid), W'(v));
    for (int k = 0; k < NR; k++)
      if (v[k]) check(rsp_data[k*W +: W] == exp[k], tag, rsp_data[k*W +: W], exp[k]);
  endtask

  localparam int NV = 9;
  localparam logic [NR-1:0]    TV_V   [NV] = '{8'hFF, 8'h0F, 8'hFF, 8'h81, 8'h0E, 8'h01, 8'hFF, 8'h00, 8'h10};
  localparam logic [NR-1:0]    TV_I   [NV] = '{8'hFF, 8'h05, 8'hFF, 8'h81, 8'h0E, 8'h00, 8'hAA, 8'h00, 8'h10};
  localparam logic [NR*IW-1:0] TV_X   [NV] = '{16'h0000, 16'h0000, 16'h4444, 16'hC002, 16'h00A8,
                                               16'h0002, 16'hE4E4, 16'h0000, 16'h0300};
  localparam bit               TV_LV  [NV] = '{0, 0, 1, 0, 1, 0, 0, 1, 0};
  localparam logic [IW-1:0]    TV_LI  [NV] = '{0, 0, 1, 0, 2, 0, 0, 3, 0};
  localparam logic [W-1:0]     TV_LD  [NV] = '{0, 0, 100, 0, 32'hFFFF_FFFE, 0, 0, 7, 0};
  // R5 R6 full prefix; R11 zero increments; R7 R9 split bases with load;
  // R4 lone requesters; R10 wrap; R11 base unchanged; mixed; R8 load; R8 read back.
  localparam string            TV_TAG [NV] = '{"R5 R6 prefix", "R11 zero inc", "R9 R7 load+split",
                                               "R4 lone", "R10 wrap", "R11 unchanged",
                                               "R5 mixed", "R8 load only", "R8 readback"};

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) mb[b] = '0;
    repeat (3) @(negedge clk);
    req_valid = '1; req_inc = '1;
    @(posedge clk); @(negedge clk);
    // R1: nothing accepted or returned under reset
    check(rsp_valid == '0, "R1 rsp_valid in reset", W'(rsp_valid), 0);
    check(req_ready == '0, "R1 ready in reset", W'(req_ready), 0);
    req_valid = '0; req_inc = '0;
    rst_n = 1'b1;
    @(negedge clk);
    // R2: accepting once out of reset
    check(req_ready == '1, "R2 ready", W'(req_ready), W'(8'hFF));
    for (int i = 0; i < NV; i++)
      apply(TV_V[i], TV_I[i], TV_X[i], TV_LV[i], TV_LI[i], TV_LD[i], TV_TAG[i]);
    // R3: idle cycle drops every response valid
    apply('0, '0, '0, 1'b0, '0, '0, "R3 idle");
    // R10 wrap again through full prefix on base 1 after a high load
    apply(8'hFF, 8'hFF, 16'h5555, 1'b1, 2'd1, 32'hFFFF_FFFC, "R10 R9 wrap full");
    apply(8'h01, 8'h00, 16'h0001, 1'b0, '0, '0, "R10 R6 after wrap");
    // R1: reset returns bases to zero
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < NB; b++) mb[b] = '0;
    apply(8'h0F, 8'h00, 16'h00E4, 1'b0, '0, '0, "R1 bases cleared");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule